// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Controller

This block produces the status output of a flash write state machine. The output can work in two ways. In level mode it shows whether the state machine is busy. In the pulse modes it gives a short low pulse of fixed width each time an operation of a chosen class completes: erase completions, program completions, or both.

The mode is set at run time by two bus writes. The first carries the command byte B8h. The second carries a code in its two low bits. The code currently in force is presented on a port of its own. A host can use the level mode to hold off accesses while the flash is busy. It can use a pulse mode as an interrupt source when a completion is what matters.

Top module: `sts_pin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cfg_mode` is 00 and the block is in level mode, so `sts_out` equals the inverse of `wsm_busy`.
- R2: A write of B8h followed by a second write whose bits 7:2 are all zero stores bits 1:0 of that second byte. The new code appears on `cfg_mode` in the cycle after the second write. Codes: 00 level, 01 erase pulses, 10 program pulses, 11 both.
- R3: If the byte after B8h has any of bits 7:2 set, the sequence is dropped and `cfg_mode` keeps its value. A write that is not preceded by B8h never changes `cfg_mode`.
- R4: In mode 00, `sts_out` is low in every cycle in which `wsm_busy` is high and high otherwise, with no delay. Completion events have no effect in this mode.
- R5: In mode 01, a `done_erase` event starts a low pulse, and a `done_prog` event alone has no effect on `sts_out`.
- R6: In mode 10, a `done_prog` event starts a low pulse, and a `done_erase` event alone has no effect on `sts_out`.
- R7: In mode 11, either completion event starts a low pulse.
- R8: In a pulse mode, a selected event sampled at a clock edge makes `sts_out` low for exactly PULSE_CYCLES cycles, starting in the following cycle. `wsm_busy` is ignored in these modes, and `sts_out` is high when no pulse is running.
- R9: A selected event that arrives while a pulse is running restarts it, so the output stays low for PULSE_CYCLES cycles after the latest event.
- R10: In the cycle after a configuration is stored, any running pulse is cleared and `sts_out` follows the new mode. An event sampled in the same cycle as the second write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_data | input | 8 | Bus write data byte |
| wsm_busy | input | 1 | High while the write state machine is working |
| done_erase | input | 1 | One-cycle erase completion event |
| done_prog | input | 1 | One-cycle program completion event |
| sts_out | output | 1 | Status pin level (low = busy or completion pulse) |
| cfg_mode | output | 2 | Configuration code in force |

## Verification
The assertions assume that each bus write lasts exactly one cycle of `wr_en`, and that completion events are single-cycle strobes sampled at the clock edge. The random stimulus therefore issues writes as isolated strobes, usually as a B8h pair but sometimes with a second byte that has reserved bits set or with no B8h in front of it. Events, busy changes and writes are drawn independently each cycle, so events can collide with a running pulse and with the cycle of a configuration write.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_ERASE = 2'b01,
        MODE_PROG  = 2'b10,
        MODE_BOTH  = 2'b11
    } sts_mode_e;

    localparam logic [7:0] CFG_COMMAND = 8'hB8;

    // A completion event is reported only in the pulse modes that select its class.
    function automatic logic event_selected(input sts_mode_e mode,
                                            input logic erase_ev,
                                            input logic prog_ev);
        logic hit;
        case (mode)
            MODE_ERASE: hit = erase_ev;
            MODE_PROG:  hit = prog_ev;
            MODE_BOTH:  hit = erase_ev | prog_ev;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Only the two low bits of the data byte may be set.
    function automatic logic reserved_clear(input logic [7:0] data);
        return data[7:2] == 6'b0;
    endfunction

endpackage

// File: rtl/sts_cfg_decoder.sv
module sts_cfg_decoder
    import sts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    output sts_mode_e mode_q,
    output logic      cfg_load
);

    logic armed_q;

    assign cfg_load = wr_en && armed_q && reserved_clear(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            mode_q  <= MODE_LEVEL;
        end else begin
            if (wr_en) begin
                armed_q <= !armed_q && (wr_data == CFG_COMMAND);
            end
            if (cfg_load) begin
                mode_q <= sts_mode_e'(wr_data[1:0]);
            end
        end
    end

    // A data byte with reserved bits set after the command leaves the mode untouched.
    assert_reserved_abort_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && armed_q && !reserved_clear(wr_data)) |=> $stable(mode_q));

    // Without a write strobe the mode cannot move.
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
    parameter int PULSE_CYCLES = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic cancel,
    input  logic trig,
    output logic active
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cancel) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign active = (cnt_q != '0);

    // A running pulse ends only from its last count or by a cancel.
    assert_min_width_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !cancel && !trig && cnt_q != ONE) |=> active);

    // A trigger always leaves the pulse at full length.
    assert_retrigger_R9: assert property (@(posedge clk) disable iff (rst)
        (trig && !cancel) |=> cnt_q == LOAD_VAL);

    // A cancel always leaves the output idle.
    assert_cancel_R10: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !active);

endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
    import sts_pkg::*;
#(
    parameter int PULSE_CYCLES = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wsm_busy,
    input  logic       done_erase,
    input  logic       done_prog,
    output logic       sts_out,
    output logic [1:0] cfg_mode
);

    sts_mode_e mode;
    logic      cfg_load;
    logic      trig;
    logic      pulse_active;
    logic      rst_seen_q;

    sts_cfg_decoder i_decoder (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode_q   (mode),
        .cfg_load (cfg_load)
    );

    assign trig = event_selected(mode, done_erase, done_prog);

    sts_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .cancel (cfg_load),
        .trig   (trig),
        .active (pulse_active)
    );

    always_comb begin
        if (mode == MODE_LEVEL) begin
            sts_out = !wsm_busy;
        end else begin
            sts_out = !pulse_active;
        end
    end

    assign cfg_mode = mode;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (!rst && rst_seen_q) begin
            assert_reset_mode_R1: assert (cfg_mode == 2'b00);
        end
    end

    // Program completions are invisible in erase-only mode.
    assert_erase_filter_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 && sts_out && !done_erase && !cfg_load) |=> sts_out);

    // Erase completions are invisible in program-only mode.
    assert_prog_filter_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10 && sts_out && !done_prog && !cfg_load) |=> sts_out);

    // After a configuration store the pin is released unless level mode reports busy.
    assert_cfg_release_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && wr_data[1:0] != 2'b00) |=> sts_out);

endmodule

// File: tb/test_sts_pin_ctrl.sv
module test_sts_pin_ctrl;

    localparam int PW = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wsm_busy;
    logic       done_erase;
    logic       done_prog;
    logic       sts_out;
    logic [1:0] cfg_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state
    int  m_mode;
    bit  m_armed;
    int  m_cnt;

    always #10 clk = ~clk;

    sts_pin_ctrl #(.PULSE_CYCLES(PW)) i_sts_pin_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wsm_busy   (wsm_busy),
        .done_erase (done_erase),
        .done_prog  (done_prog),
        .sts_out    (sts_out),
        .cfg_mode   (cfg_mode)
    );

    function automatic bit selected(int mode, bit er, bit pr);
        if (mode == 1) return er;
        if (mode == 2) return pr;
        if (mode == 3) return er | pr;
        return 1'b0;
    endfunction

    function automatic bit expected_pin(int mode, int cnt, bit busy);
        if (mode == 0) return !busy;
        return cnt == 0;
    endfunction

    task automatic check(string tag);
        bit exp_pin;
        exp_pin = expected_pin(m_mode, m_cnt, wsm_busy);
        checks++;
        if (sts_out !== exp_pin) begin
            errors++;
            $display("FAIL %s sts_out actual=%b expected=%b t=%0t", tag, sts_out, exp_pin, $time);
        end
        checks++;
        if (cfg_mode !== 2'(m_mode)) begin
            errors++;
            $display("FAIL %s cfg_mode actual=%0d expected=%0d t=%0t", tag, cfg_mode, m_mode, $time);
        end
    endtask

    // Inputs are applied after a falling edge, outputs checked, then the model advances.
    task automatic step(string tag, bit we, logic [7:0] d, bit busy, bit er, bit pr);
        bit load;
        wr_en = we; wr_data = d; wsm_busy = busy; done_erase = er; done_prog = pr;
        #1;
        check(tag);
        @(posedge clk);
        load = we && m_armed && (d[7:2] == 6'b0);
        if (we) m_armed = !m_armed && (d == 8'hB8);
        if (load) begin
            m_mode = int'(d[1:0]);
            m_cnt  = 0;
        end else if (m_mode != 0 && selected(m_mode, er, pr)) begin
            m_cnt = PW;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n, bit busy);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h00, busy, 1'b0, 1'b0);
    endtask

    task automatic configure(string tag, logic [7:0] code);
        step(tag, 1'b1, 8'hB8, 1'b0, 1'b0, 1'b0);
        step(tag, 1'b1, code, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; wsm_busy = 1'b0;
        done_erase = 1'b0; done_prog = 1'b0;
        m_mode = 0; m_armed = 1'b0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with busy high and low
        wsm_busy = 1'b1; #1; check("R1");
        wsm_busy = 1'b0; #1; check("R1");
        rst = 1'b0;
        idle("R1", 1, 1'b0);

        // R4: level mode follows busy, events ignored
        step("R4", 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
        step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        idle("R4", 2, 1'b0);

        // R3: data without command, and command followed by reserved bits set
        step("R3", 1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
        idle("R3", 1, 1'b0);
        step("R3", 1'b1, 8'hB8, 1'b0, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h41, 1'b0, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
        idle("R3", 1, 1'b0);

        // R2 / R6: program-only mode
        configure("R2", 8'h02);
        step("R6", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
        idle("R6", 2, 1'b1);
        step("R6", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R8", PW + 2, 1'b1);

        // R9: retrigger in the middle of a pulse
        step("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R9", PW - 2, 1'b0);
        step("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R9", PW + 1, 1'b0);

        // R10: configuration during a pulse, with an event in the store cycle
        step("R10", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R10", 1, 1'b0);
        step("R10", 1'b1, 8'hB8, 1'b0, 1'b0, 1'b0);
        step("R10", 1'b1, 8'h01, 1'b0, 1'b1, 1'b1);
        idle("R10", 2, 1'b1);

        // R5: erase-only mode
        step("R5", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R5", 2, 1'b0);
        step("R5", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        idle("R8", PW + 1, 1'b0);

        // R7: both classes
        configure("R2", 8'h03);
        step("R7", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        idle("R7", PW + 1, 1'b0);
        step("R7", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle("R7", PW + 1, 1'b0);

        // R10: back to level mode while pulsing
        step("R10", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        configure("R10", 8'h00);
        step("R4", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);

        // random phase
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit we;
            logic [7:0] d;
            r = int'($urandom_range(0, 99));
            we = 1'b0;
            d  = 8'h00;
            if (r < 6) begin
                we = 1'b1; d = 8'hB8;
            end else if (r < 12) begin
                we = 1'b1; d = {6'b0, 2'($urandom_range(0, 3))};
            end else if (r < 14) begin
                we = 1'b1; d = 8'($urandom_range(0, 255));
            end
            step(m_mode == 0 ? "R4" : "R8", we, d,
                 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 9) == 0));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule